// File: doc/BRIEF.md
# Unified Direct-Mapped Cache

This block is a single cache that serves both instruction fetches and data accesses of a processor. Each 32-bit word request is looked up in one direct-mapped array of lines. Every line holds four words. A tag memory keeps the tag and valid flag of each line, and a separate data memory keeps the words. Both memories are read in the same cycle. The word read out is used only when the stored tag equals the request's tag and the line is valid. Otherwise it is thrown away.

When a read misses, the controller stalls the processor and fetches the entire line from a slower backing memory. That memory delivers its first word four cycles after the request and each further word one cycle later. Once the line is installed, the requested word is returned. Stores are written through to memory and do not allocate a line. A store that hits also updates the cached word. Reset invalidates every line.

The processor holds `cpu_req` and its operands stable until `cpu_ready` pulses. On that cycle `cpu_rdata` carries the load result.

Top module: `ucache_top`

## Requirements
- R1: After reset, `cpu_ready`, `mem_rd` and `mem_wr` are low, and the first load to every one of the 64 lines misses.
- R2: A load hit raises `cpu_ready` on the 2nd rising edge after the request is presented and issues no backing-memory read.
- R3: A load miss issues exactly one single-cycle `mem_rd` pulse, and its `mem_addr` is aligned to the 16-byte line (bits 3:0 zero).
- R4: A load miss returns the requested word for any word offset, with `cpu_ready` on the 10th rising edge after the request. The backing memory delivers four beats, the first 4 cycles after the read pulse and the rest 1 cycle apart.
- R5: After a refill, loads to every word of that line hit and return the line's contents.
- R6: A load whose index matches a cached line but whose tag (address bits 31:10) differs misses and replaces that line. A later load of the evicted address misses again.
- R7: A store that hits writes the word to memory and to the cache, acknowledges after 5 rising edges, and a following load hits with the new value.
- R8: A store that misses writes memory only, issues no `mem_rd`, and leaves the line absent, so the next load to it misses and returns the stored value.
- R9: `cpu_ready` stays low while an access is in progress and is high for exactly one cycle per access.
- R10: Address bits 1:0 are ignored. A load with any byte offset returns the word selected by bits 31:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | 32 | Backing-memory byte address |
| mem_rd | output | 1 | One-cycle line-read request |
| mem_wr | output | 1 | One-cycle word-write request |
| mem_wdata | output | 32 | Backing-memory write data |
| mem_rdata | input | 32 | Backing-memory read beat |
| mem_valid | input | 1 | Read beat present, or write acknowledged |

## Verification
The bench first loads each index once after reset, so every load must miss. A design that kept stale valid flags would answer one of them in two cycles. It then sweeps every word of the cached range, using a different word offset for each refill. A refill that wrote beats to the wrong slot, or captured the wrong beat for the processor, returns a value that differs from the arithmetic memory image.

Tags that collide on the same index must evict and then miss again. A design that compared too few tag bits would report false hits. A store hit followed by a load catches a cache that skips its own update and returns stale data. A store miss followed by a load catches write-allocation, which would show up either as a `mem_rd` pulse or as a two-cycle hit.

// File: rtl/ucache_pkg.sv
package ucache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2,
    ST_WACK   = 2'd3
  } ctrl_state_t;

endpackage

// File: rtl/ucache_tag_store.sv
module ucache_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_ram [LINES];
  logic [LINES-1:0] valid_q;

  // tag memory: no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) tag_ram[wr_idx] <= wr_tag;
    rd_tag <= tag_ram[rd_idx];
  end

  // valid flags kept in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (we) valid_q[wr_idx] <= 1'b1;
      rd_valid <= valid_q[rd_idx];
    end
  end

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    we |=> valid_q[$past(wr_idx)]); // R5

endmodule

// File: rtl/ucache_data_store.sv
module ucache_data_store #(
  parameter int AW     = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] ram [DEPTH];

  // simple dual-port memory, registered read, old data on collision
  always_ff @(posedge clk) begin
    if (we) ram[wr_addr] <= wr_data;
    rd_data <= ram[rd_addr];
  end

endmodule

// File: rtl/ucache_ctrl.sv
module ucache_ctrl
  import ucache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int WOFF_W = 2,
  parameter int BYTE_W = 2,
  parameter int TAG_W  = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-BYTE_W-1:0] cpu_waddr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  input  logic [TAG_W-1:0]        look_tag,
  input  logic                    look_valid,
  input  logic [DATA_W-1:0]       look_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_valid,
  output logic                    tag_we,
  output logic [IDX_W-1:0]        tag_wr_idx,
  output logic [TAG_W-1:0]        tag_wr_tag,
  output logic                    dat_we,
  output logic [IDX_W+WOFF_W-1:0] dat_wr_addr,
  output logic [DATA_W-1:0]       dat_wr_data
);
  localparam int WA_W   = ADDR_W - BYTE_W;
  localparam int LINE_W = BYTE_W + WOFF_W;

  ctrl_state_t       state_q;
  logic [WA_W-1:0]   waddr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WOFF_W-1:0] beat_q;

  logic [IDX_W-1:0]  idx_q;
  logic [WOFF_W-1:0] word_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit;
  logic              last_beat;
  logic              fill_beat;

  assign idx_q     = waddr_q[WOFF_W +: IDX_W];
  assign word_q    = waddr_q[WOFF_W-1:0];
  assign tag_q     = waddr_q[WA_W-1 -: TAG_W];
  assign hit       = look_valid && (look_tag == tag_q);
  assign last_beat = &beat_q;
  assign fill_beat = (state_q == ST_FILL) && mem_valid;

  // array write side: refill beats, or the word of a store hit
  always_comb begin
    tag_we      = fill_beat && last_beat;
    tag_wr_idx  = idx_q;
    tag_wr_tag  = tag_q;
    dat_we      = fill_beat || ((state_q == ST_LOOKUP) && we_q && hit);
    dat_wr_addr = {idx_q, (state_q == ST_FILL) ? beat_q : word_q};
    dat_wr_data = (state_q == ST_FILL) ? mem_rdata : wdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      waddr_q   <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      beat_q    <= '0;
      cpu_rdata <= '0;
      cpu_ready <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            waddr_q <= cpu_waddr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (we_q) begin
            // write-through, no allocate
            mem_wr    <= 1'b1;
            mem_addr  <= {waddr_q, {BYTE_W{1'b0}}};
            mem_wdata <= wdata_q;
            state_q   <= ST_WACK;
          end else if (hit) begin
            cpu_rdata <= look_data;
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= {waddr_q[WA_W-1:WOFF_W], {LINE_W{1'b0}}};
            beat_q   <= '0;
            state_q  <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_valid) begin
            if (beat_q == word_q) cpu_rdata <= mem_rdata;
            beat_q <= beat_q + 1'b1;
            if (last_beat) begin
              cpu_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_WACK: begin
          if (mem_valid) begin
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R9
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[LINE_W-1:0] == '0)); // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R8
  AST_STORE_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && we_q) |=> !mem_rd); // R8
  AST_FILL_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    (fill_beat && last_beat) |=> cpu_ready); // R4

endmodule

// File: rtl/ucache_top.sv
module ucache_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_valid
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WOFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int IDX_LSB = BYTE_W + WOFF_W;
  localparam int TAG_W   = ADDR_W - IDX_LSB - IDX_W;
  localparam int DAT_AW  = IDX_W + WOFF_W;

  logic [TAG_W-1:0]  look_tag;
  logic              look_valid;
  logic [DATA_W-1:0] look_data;
  logic              tag_we;
  logic [IDX_W-1:0]  tag_wr_idx;
  logic [TAG_W-1:0]  tag_wr_tag;
  logic              dat_we;
  logic [DAT_AW-1:0] dat_wr_addr;
  logic [DATA_W-1:0] dat_wr_data;
  logic              unused_byte_bits;

  // byte lanes play no part in a word cache
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  ucache_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (cpu_addr[IDX_LSB +: IDX_W]),
    .rd_tag   (look_tag),
    .rd_valid (look_valid),
    .we       (tag_we),
    .wr_idx   (tag_wr_idx),
    .wr_tag   (tag_wr_tag)
  );

  ucache_data_store #(
    .AW     (DAT_AW),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_addr (cpu_addr[BYTE_W +: DAT_AW]),
    .rd_data (look_data),
    .we      (dat_we),
    .wr_addr (dat_wr_addr),
    .wr_data (dat_wr_data)
  );

  ucache_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .WOFF_W (WOFF_W),
    .BYTE_W (BYTE_W),
    .TAG_W  (TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_waddr   (cpu_addr[ADDR_W-1:BYTE_W]),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .cpu_ready   (cpu_ready),
    .look_tag    (look_tag),
    .look_valid  (look_valid),
    .look_data   (look_data),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_valid   (mem_valid),
    .tag_we      (tag_we),
    .tag_wr_idx  (tag_wr_idx),
    .tag_wr_tag  (tag_wr_tag),
    .dat_we      (dat_we),
    .dat_wr_addr (dat_wr_addr),
    .dat_wr_data (dat_wr_data)
  );

endmodule

// File: tb/tb_ucache_top.sv
module tb_ucache_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_valid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ucache_top dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid)
  );

  // behavioural backing memory: 4096 words
  logic [31:0] mem_model [4096];
  logic [31:0] exp_mem   [4096];
  logic [2:0]  rd_cnt = '0;
  logic [1:0]  wr_cnt = '0;
  logic [9:0]  rd_base = '0;
  logic [31:0] last_rd_addr = '0;
  int rd_pulses = 0;
  int wr_pulses = 0;

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      if (mem_rd) begin
        rd_cnt       <= 3'd1;
        rd_base      <= mem_addr[13:4];
        last_rd_addr <= mem_addr;
        rd_pulses    <= rd_pulses + 1;
      end else if (rd_cnt != 0) begin
        rd_cnt <= (rd_cnt == 3'd7) ? 3'd0 : rd_cnt + 3'd1;
      end
      if (mem_wr) begin
        mem_model[mem_addr[13:2]] <= mem_wdata;
        wr_cnt    <= 2'd1;
        wr_pulses <= wr_pulses + 1;
      end else if (wr_cnt != 0) begin
        wr_cnt <= (wr_cnt == 2'd2) ? 2'd0 : wr_cnt + 2'd1;
      end
    end
  end

  logic [1:0] beat_sel;
  assign beat_sel  = rd_cnt[1:0];
  assign mem_valid = (rd_cnt >= 3'd4) || (wr_cnt == 2'd2);
  assign mem_rdata = (rd_cnt >= 3'd4) ? mem_model[{rd_base, beat_sel}] : 32'h0;

  // requirement-level model of line residency
  bit          ref_v [64];
  logic [21:0] ref_t [64];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_access(input logic we, input logic [31:0] a,
                            input logic [31:0] wd, input string rq);
    int          idx;
    logic [21:0] tg;
    bit          exp_hit;
    int          exp_lat;
    int          rd0;
    int          wr0;
    int          lat;
    logic [31:0] got;
    idx     = int'(a[9:4]);
    tg      = a[31:10];
    exp_hit = ref_v[idx] && (ref_t[idx] == tg);
    exp_lat = we ? 5 : (exp_hit ? 2 : 10);
    rd0     = rd_pulses;
    wr0     = wr_pulses;
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_addr  = a;
    cpu_wdata = wd;
    lat       = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!cpu_ready && lat < 40);
    got     = cpu_rdata;
    cpu_req = 1'b0;
    chk(lat == exp_lat, we ? (exp_hit ? "R7" : "R8") : (exp_hit ? "R2" : "R4"),
        "latency", 32'(lat), 32'(exp_lat));
    if (!we) begin
      chk(got == exp_mem[a[13:2]], rq, "load data", got, exp_mem[a[13:2]]);
      chk((rd_pulses - rd0) == (exp_hit ? 0 : 1), "R3", "mem_rd pulses",
          32'(rd_pulses - rd0), exp_hit ? 32'd0 : 32'd1);
      if (!exp_hit) begin
        chk(last_rd_addr == {a[31:4], 4'b0}, "R3", "fill address",
            last_rd_addr, {a[31:4], 4'b0});
        ref_v[idx] = 1'b1;
        ref_t[idx] = tg;
      end
    end else begin
      exp_mem[a[13:2]] = wd;
      chk(mem_model[a[13:2]] == wd, rq, "memory after store",
          mem_model[a[13:2]], wd);
      chk((wr_pulses - wr0) == 1 && rd_pulses == rd0, "R8", "store traffic",
          32'(rd_pulses - rd0), 32'd0);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!cpu_ready, "R9", "ready pulse width", 32'(cpu_ready), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_model[i] = init_word(i);
      exp_mem[i]   = init_word(i);
    end
    for (int i = 0; i < 64; i++) begin
      ref_v[i] = 1'b0;
      ref_t[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk(!cpu_ready && !mem_rd && !mem_wr, "R1", "outputs after reset",
        {29'd0, cpu_ready, mem_rd, mem_wr}, 32'd0);

    // R1 / R4: cold misses, word offset varied per line
    for (int i = 0; i < 64; i++)
      run_access(1'b0, 32'(i * 16 + (i % 4) * 4), 32'h0, "R1");

    // R5 / R2: every word of every line now hits
    for (int i = 0; i < 256; i++)
      run_access(1'b0, 32'(i * 4), 32'h0, "R5");

    // R10: byte offsets are ignored
    for (int i = 0; i < 12; i++)
      run_access(1'b0, 32'(i * 20 * 4 + (i % 3) + 1), 32'h0, "R10");

    // R6: conflicting tags on one index evict and miss again
    for (int i = 0; i < 64; i += 7) begin
      run_access(1'b0, 32'(32'h400 * (1 + i % 3) + i * 16 + 8), 32'h0, "R6");
      run_access(1'b0, 32'(i * 16), 32'h0, "R6");
    end

    // R7: store hits then read back
    for (int i = 0; i < 8; i++) begin
      run_access(1'b0, 32'(i * 16 + 4), 32'h0, "R7");
      run_access(1'b1, 32'(i * 16 + 4), 32'hC0DE_0000 + 32'(i), "R7");
      run_access(1'b0, 32'(i * 16 + 4), 32'h0, "R7");
    end

    // R8: store misses do not allocate
    for (int i = 0; i < 8; i++) begin
      run_access(1'b1, 32'(32'h2000 + i * 16 + 12), 32'hBEEF_0000 + 32'(i), "R8");
      run_access(1'b0, 32'(32'h2000 + i * 16 + 12), 32'h0, "R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule